// File: doc/BRIEF.md
# Self-timed EEPROM access controller

This block controls a 128-byte nonvolatile byte store for a small CPU. The CPU reaches it through three byte-wide registers on its I/O bus: an address register, a data register and a control register. A write needs two steps. Software first arms a master enable, and that enable removes itself after a short window. Inside the window, software sets the write strobe. The write then runs by itself and counts a fixed number of ticks from a slow timing strobe. A busy bit stays high until the write is done and then clears in hardware. A write that has started finishes even when the system reset is asserted during it.

A read takes one access. The CPU is held by a stall request for a few cycles. When the stall ends, the data register holds the addressed byte. Starting a write also stalls the CPU, for a shorter time. A level interrupt reports that the store is ready. A status output flags a write whose result can no longer be trusted. This happens when software changes the address or data register while that write is running. A behavioural storage array stands in for the cell array. There are two resets. The power-on reset clears the write engine. The system reset clears only the register file and the sequencers.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00, and `cpu_stall`, `ready_irq` and `write_undef` are low. The register select codes are 0 for address, 1 for data and 2 for control. Code 3 reads 0x00.
- R2: Address register bit 7 always reads 0, and bits 6..0 hold the written value. Control register bits 7..4 always read 0. The data register holds all 8 written bits.
- R3: Control bit 2 is the master arm. After a control write with bit 2 set, it reads 1 for four cycles. Hardware then clears it, so it reads 0 from the fifth sample on.
- R4: Control bit 1 is the write strobe. Writing 1 to it starts a write only if the arm reads 1 in that cycle. After the start, bit 1 reads 1. With the arm clear, for example when it was never set or has already expired, the strobe has no effect.
- R5: A write lasts WRITE_TICKS cycles in which `tick_en` is high. Cycles with `tick_en` low do not count. At the end, control bit 1 clears and the byte is stored.
- R6: Starting a write raises `cpu_stall` for exactly 2 cycles.
- R7: Control bit 0 is the read strobe. Writing 1 to it raises `cpu_stall` for exactly 4 cycles, with bit 0 reading 1 during that time. After that, the data register holds the stored byte at the address register, and bit 0 reads 0.
- R8: Control bit 3 is the interrupt enable. `ready_irq` is high exactly when bit 3 is 1 and no write is busy.
- R9: A system reset asserted during a write does not stop it. Control bit 1 stays 1, and the byte latched at the start is stored.
- R10: A read strobe issued while a write is busy is ignored. No stall occurs, bit 0 stays 0, and the data register is unchanged.
- R11: During a busy write, writes to the address and data registers are accepted and read back. They raise `write_undef`, which stays high until the next write starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears the write engine |
| rst_n | input | 1 | System reset, active low; spares a running write |
| tick_en | input | 1 | Timing strobe that paces the write timer |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register |
| cpu_stall | output | 1 | CPU hold request |
| ready_irq | output | 1 | Ready interrupt level |
| write_undef | output | 1 | The last write's stored result is undefined |

## Verification
Two collisions are exercised.

The first is the write strobe landing on the exact edge where the arm expires. The bench arms the block, waits three cycles and strobes in the fourth. A busy bit of 1 with the arm reading 0 shows that the start won over the expiry. A strobe one cycle later must leave the block idle.

The second is a system reset pulse during a running write. The bench checks that busy stays high through the reset. It then reads the address back after completion and confirms the latched byte reached the array, while the registers themselves were cleared.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
   localparam int REG_W = 8;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } nvm_sel_e;

   // control register bit positions (software decodes these)
   localparam int CB_READ  = 0;
   localparam int CB_GO    = 1;
   localparam int CB_ARM   = 2;
   localparam int CB_IRQEN = 3;
endpackage

// File: rtl/nvm_arm_window.sv
`timescale 1ns/1ps
module nvm_arm_window #(
   parameter int ARM_WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   output logic arm_o
);
   localparam int AW = $clog2(ARM_WINDOW + 1);

   logic [AW-1:0] left_q;
   logic          arm_q;

   initial begin : param_chk
      assert (ARM_WINDOW >= 1) else $error("ARM_WINDOW must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q  <= 1'b0;
         left_q <= '0;
      end else if (arm_set) begin
         arm_q  <= 1'b1;
         left_q <= AW'(ARM_WINDOW - 1);
      end else if (arm_q) begin
         if (left_q == '0) arm_q <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end
   end

   assign arm_o = arm_q;

   // checker: age of the arm since it was last set
   logic [AW:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)       age_q <= '0;
      else if (arm_set) age_q <= '0;
      else if (arm_q)   age_q <= age_q + 1'b1;
   end

   // R3
   arm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q |-> (age_q < (AW+1)'(ARM_WINDOW)));
endmodule

// File: rtl/nvm_write_engine.sv
`timescale 1ns/1ps
module nvm_write_engine #(
   parameter int ADDR_W           = 7,
   parameter int DATA_W           = 8,
   parameter int WRITE_TICKS      = 8448,
   parameter bit MEM_CLEAR_ON_POR = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              tick_en,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] start_data,
   input  logic              reg_touch,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_byte,
   output logic              busy_o,
   output logic              undef_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int CW    = $clog2(WRITE_TICKS + 1);

   logic              busy_q;
   logic [CW-1:0]     cnt_q;
   logic [ADDR_W-1:0] lat_addr_q;
   logic [DATA_W-1:0] lat_data_q;
   logic              undef_q;
   logic              commit;

   initial begin : param_chk
      assert (WRITE_TICKS >= 2) else $error("WRITE_TICKS must be at least 2");
      assert (DEPTH <= 4096) else $error("array too large");
   end

   assign commit = busy_q && tick_en && (cnt_q == CW'(1));

   always_ff @(posedge clk) begin
      if (!por_n) begin
         busy_q     <= 1'b0;
         cnt_q      <= '0;
         lat_addr_q <= '0;
         lat_data_q <= '0;
         undef_q    <= 1'b0;
      end else if (start) begin
         busy_q     <= 1'b1;
         cnt_q      <= CW'(WRITE_TICKS);
         lat_addr_q <= start_addr;
         lat_data_q <= start_data;
         undef_q    <= 1'b0;
      end else if (busy_q) begin
         if (reg_touch) undef_q <= 1'b1;
         if (tick_en) begin
            if (cnt_q == CW'(1)) busy_q <= 1'b0;
            else                 cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (MEM_CLEAR_ON_POR) begin : g_mem_clr
         always_ff @(posedge clk) begin
            if (!por_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (commit) begin
               mem[lat_addr_q] <= lat_data_q;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (commit) mem[lat_addr_q] <= lat_data_q;
         end
      end
   endgenerate

   assign rd_byte = mem[rd_addr];
   assign busy_o  = busy_q;
   assign undef_o = undef_q;

   // R5
   tick_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      (busy_q && !tick_en && !start) |=> busy_q);
   // R9
   write_survive_chk: assert property (@(posedge clk) disable iff (!por_n)
      (busy_q && cnt_q > CW'(1)) |=> busy_q);
   // R11
   undef_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (undef_q && !start) |=> undef_q);
endmodule

// File: rtl/nvm_stall_seq.sv
`timescale 1ns/1ps
module nvm_stall_seq #(
   parameter int WR_STALL = 2,
   parameter int RD_STALL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_wr,
   input  logic start_rd,
   output logic stall_o,
   output logic rd_pend_o,
   output logic rd_done_o
);
   localparam int MAXS = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
   localparam int SW   = $clog2(MAXS + 1);

   logic [SW-1:0] cnt_q;
   logic          rd_pend_q;

   initial begin : param_chk
      assert (WR_STALL >= 1 && RD_STALL >= 1) else $error("stall lengths must be positive");
   end

   assign rd_done_o = rd_pend_q && (cnt_q == SW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         rd_pend_q <= 1'b0;
      end else if (start_wr) begin
         cnt_q <= SW'(WR_STALL);
      end else if (start_rd) begin
         cnt_q     <= SW'(RD_STALL);
         rd_pend_q <= 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (rd_done_o) rd_pend_q <= 1'b0;
      end
   end

   assign stall_o   = (cnt_q != '0);
   assign rd_pend_o = rd_pend_q;

   // R7
   rd_stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_rd |=> (stall_o && rd_pend_o));
   // R6
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_o) |-> $past(start_wr || start_rd));
endmodule

// File: rtl/nvm_access_ctrl.sv
`timescale 1ns/1ps
module nvm_access_ctrl #(
   parameter int ADDR_W           = 7,
   parameter int WRITE_TICKS      = 8448,
   parameter int ARM_WINDOW       = 4,
   parameter int WR_STALL         = 2,
   parameter int RD_STALL         = 4,
   parameter bit MEM_CLEAR_ON_POR = 1'b0
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic [1:0] bus_sel,
   input  logic       bus_wr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       cpu_stall,
   output logic       ready_irq,
   output logic       write_undef
);
   import nvm_pkg::*;

   localparam int PAD_W = REG_W - ADDR_W;

   initial begin : param_chk
      assert (ADDR_W >= 1 && ADDR_W < REG_W) else $error("ADDR_W must fit below the register width");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [REG_W-1:0]  data_q;
   logic              irq_en_q;

   logic wr_addr, wr_data, wr_ctrl;
   logic arm_set, go_req, rd_req;
   logic arm, busy, rd_pend, rd_done, undef;
   logic start_wr, start_rd;
   logic [REG_W-1:0] rd_byte;

   assign wr_addr = bus_wr && (bus_sel == SEL_ADDR);
   assign wr_data = bus_wr && (bus_sel == SEL_DATA);
   assign wr_ctrl = bus_wr && (bus_sel == SEL_CTRL);
   assign arm_set = wr_ctrl && bus_wdata[CB_ARM];
   assign go_req  = wr_ctrl && bus_wdata[CB_GO];
   assign rd_req  = wr_ctrl && bus_wdata[CB_READ];

   assign start_wr = go_req && arm && !busy && !rd_pend;
   assign start_rd = rd_req && !go_req && !busy && !rd_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         data_q   <= '0;
         irq_en_q <= 1'b0;
      end else begin
         if (wr_addr) addr_q   <= bus_wdata[ADDR_W-1:0];
         if (wr_data) data_q   <= bus_wdata;
         if (wr_ctrl) irq_en_q <= bus_wdata[CB_IRQEN];
         if (rd_done) data_q   <= rd_byte;
      end
   end

   nvm_arm_window #(.ARM_WINDOW(ARM_WINDOW)) u_arm (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_set(arm_set),
      .arm_o  (arm)
   );

   nvm_write_engine #(
      .ADDR_W          (ADDR_W),
      .DATA_W          (REG_W),
      .WRITE_TICKS     (WRITE_TICKS),
      .MEM_CLEAR_ON_POR(MEM_CLEAR_ON_POR)
   ) u_eng (
      .clk       (clk),
      .por_n     (por_n),
      .tick_en   (tick_en),
      .start     (start_wr),
      .start_addr(addr_q),
      .start_data(data_q),
      .reg_touch (wr_addr || wr_data),
      .rd_addr   (addr_q),
      .rd_byte   (rd_byte),
      .busy_o    (busy),
      .undef_o   (undef)
   );

   nvm_stall_seq #(.WR_STALL(WR_STALL), .RD_STALL(RD_STALL)) u_stall (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_wr (start_wr),
      .start_rd (start_rd),
      .stall_o  (cpu_stall),
      .rd_pend_o(rd_pend),
      .rd_done_o(rd_done)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_sel)
         SEL_ADDR: bus_rdata = {{PAD_W{1'b0}}, addr_q};
         SEL_DATA: bus_rdata = data_q;
         SEL_CTRL: begin
            bus_rdata[CB_IRQEN] = irq_en_q;
            bus_rdata[CB_ARM]   = arm;
            bus_rdata[CB_GO]    = busy;
            bus_rdata[CB_READ]  = rd_pend;
         end
         default:  bus_rdata = '0;
      endcase
   end

   assign ready_irq   = irq_en_q && !busy;
   assign write_undef = undef;

   // R8
   irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_irq |-> !busy);
   // R4
   no_arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (go_req && !arm && !busy) |=> !busy);
   // R10
   rd_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (rd_req && busy && !rd_pend) |=> !rd_pend);
endmodule

// File: tb/nvm_access_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_access_ctrl_tb;
   localparam int TICKS = 16;
   localparam logic [1:0] SA = 2'd0, SD = 2'd1, SC = 2'd2;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, rst_n = 1'b0, tick_en = 1'b1;
   logic [1:0] bus_sel = SA;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cpu_stall, ready_irq, write_undef;

   int nvec = 0, nfail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nvm_access_ctrl #(.WRITE_TICKS(TICKS)) u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cpu_stall(cpu_stall), .ready_irq(ready_irq),
      .write_undef(write_undef)
   );

   // {select, write value, expected readback}
   localparam logic [17:0] VEC [6] = '{
      {SA, 8'hFF, 8'h7F},
      {SA, 8'h25, 8'h25},
      {SD, 8'hA5, 8'hA5},
      {SD, 8'h3C, 8'h3C},
      {SC, 8'hF8, 8'h08},
      {SC, 8'h00, 8'h00}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bwrite(input logic [1:0] s, input logic [7:0] d);
      bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] s, output logic [7:0] v);
      bus_sel = s;
      #0.5 v = bus_rdata;
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
      summary();
   end

   initial begin : main
      logic [7:0] v;
      step(3);
      por_n = 1'b1; rst_n = 1'b1;
      step(1);

      // R1 reset state
      rreg(SA, v); chk("R1 addr", v, 8'h00);
      rreg(SD, v); chk("R1 data", v, 8'h00);
      rreg(SC, v); chk("R1 ctrl", v, 8'h00);
      rreg(2'd3, v); chk("R1 unused select", v, 8'h00);
      chk("R1 stall/irq/undef", {5'b0, cpu_stall, ready_irq, write_undef}, 8'h00);

      // R2 register vectors
      for (int i = 0; i < 6; i++) begin
         bwrite(VEC[i][17:16], VEC[i][15:8]);
         rreg(VEC[i][17:16], v);
         chk($sformatf("R2 vector %0d", i), v, VEC[i][7:0]);
      end

      // R8 interrupt when idle
      bwrite(SC, 8'h08);
      chk("R8 irq idle", {7'b0, ready_irq}, 8'h01);

      // R3 arm window
      bwrite(SC, 8'h04);
      rreg(SC, v); chk("R3 arm k0", v, 8'h04);
      step(3); rreg(SC, v); chk("R3 arm k3", v, 8'h04);
      step(1); rreg(SC, v); chk("R3 arm cleared", v, 8'h00);

      // R4 strobe without arm
      bwrite(SC, 8'h02);
      rreg(SC, v); chk("R4 no arm", v, 8'h00);
      chk("R4 no arm stall", {7'b0, cpu_stall}, 8'h00);
      // R4 strobe after window
      bwrite(SC, 8'h04);
      step(4);
      bwrite(SC, 8'h02);
      rreg(SC, v); chk("R4 late strobe", v, 8'h00);

      // R4 R6 R8 R5: strobe on the last armed cycle
      bwrite(SA, 8'h10);
      bwrite(SD, 8'h5A);
      bwrite(SC, 8'h0C);
      chk("R8 irq armed idle", {7'b0, ready_irq}, 8'h01);
      step(3);
      bwrite(SC, 8'h0A);
      rreg(SC, v); chk("R4 start at window edge", v, 8'h0A);
      chk("R6 stall k0", {7'b0, cpu_stall}, 8'h01);
      chk("R8 irq busy", {7'b0, ready_irq}, 8'h00);
      step(1); chk("R6 stall k1", {7'b0, cpu_stall}, 8'h01);
      step(1); chk("R6 stall end", {7'b0, cpu_stall}, 8'h00);
      step(13); rreg(SC, v); chk("R5 busy before end", v, 8'h0A);
      step(1); rreg(SC, v); chk("R5 busy cleared", v, 8'h08);
      chk("R8 irq after write", {7'b0, ready_irq}, 8'h01);
      chk("R11 undef clean", {7'b0, write_undef}, 8'h00);

      // R7 read
      bwrite(SD, 8'h00);
      bwrite(SC, 8'h01);
      rreg(SC, v); chk("R7 read pending", v, 8'h01);
      chk("R7 stall k0", {7'b0, cpu_stall}, 8'h01);
      step(3); chk("R7 stall k3", {7'b0, cpu_stall}, 8'h01);
      step(1); chk("R7 stall end", {7'b0, cpu_stall}, 8'h00);
      rreg(SD, v); chk("R7 read data", v, 8'h5A);
      rreg(SC, v); chk("R7 read bit clears", v, 8'h00);

      // R5 tick gating
      tick_en = 1'b0;
      bwrite(SA, 8'h20);
      bwrite(SD, 8'hC3);
      bwrite(SC, 8'h04);
      bwrite(SC, 8'h02);
      step(30);
      rreg(SC, v); chk("R5 no ticks keeps busy", v, 8'h02);
      tick_en = 1'b1;
      step(15); rreg(SC, v); chk("R5 gated busy", v, 8'h02);
      step(1);  rreg(SC, v); chk("R5 gated done", v, 8'h00);
      bwrite(SC, 8'h01);
      step(4); rreg(SD, v); chk("R5 gated stored", v, 8'hC3);

      // R10 R11 register access during a busy write
      bwrite(SA, 8'h30);
      bwrite(SD, 8'h11);
      bwrite(SC, 8'h04);
      bwrite(SC, 8'h02);
      step(2);
      bwrite(SC, 8'h01);
      chk("R10 no stall", {7'b0, cpu_stall}, 8'h00);
      rreg(SC, v); chk("R10 read ignored", v, 8'h02);
      rreg(SD, v); chk("R10 data unchanged", v, 8'h11);
      bwrite(SD, 8'h77);
      chk("R11 undef raised", {7'b0, write_undef}, 8'h01);
      rreg(SD, v); chk("R11 data accepted", v, 8'h77);
      step(12);
      rreg(SC, v); chk("R11 write done", v, 8'h00);
      chk("R11 undef held", {7'b0, write_undef}, 8'h01);
      bwrite(SC, 8'h01);
      step(4); rreg(SD, v); chk("R11 latched byte", v, 8'h11);
      bwrite(SA, 8'h31);
      bwrite(SC, 8'h04);
      bwrite(SC, 8'h02);
      chk("R11 undef cleared", {7'b0, write_undef}, 8'h00);
      step(16);

      // R9 system reset during a write
      bwrite(SA, 8'h40);
      bwrite(SD, 8'h9E);
      bwrite(SC, 8'h04);
      bwrite(SC, 8'h02);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      rreg(SC, v); chk("R9 busy through reset", v, 8'h02);
      rreg(SD, v); chk("R9 data reg reset", v, 8'h00);
      step(20);
      rreg(SC, v); chk("R9 write finished", v, 8'h00);
      bwrite(SA, 8'h40);
      bwrite(SC, 8'h01);
      step(4); rreg(SD, v); chk("R9 byte stored", v, 8'h9E);

      summary();
   end
endmodule